// File: doc/BRIEF.md
# Next-Interrupt Register Access Unit

This block carries out one read-modify-write access to the machine-level "next interrupt" control register of a core-local interrupt controller. Each access can set or clear two interrupt-enable bits. The access comes in either an immediate form or a register form. The unit then tests whether the highest-ranked pending interrupt outranks both the previous interrupt level and the level threshold. If it does, and the operand allows side effects, the hart commits to that interrupt: the current interrupt level and the cause code take the pending interrupt's level and ID.

The value returned to the destination register is the address of the pending interrupt's entry in the vector table. That address is the table base plus the ID times four. The value is zero when no interrupt qualifies or when the controller is not in vectored mode. A software handler uses this to chain from one interrupt to the next without taking a new trap.

The whole access takes one cycle. The result is presented combinationally while the strobe is high, and every register update lands on the clock edge that samples the strobe.

Top module: `nxti_access_unit`

## Requirements
- R1: After reset, the machine enable, the supervisor enable, the current level and the cause code are all zero.
- R2: A set-form access ORs operand bit 3 into the machine enable and operand bit 1 into the supervisor enable. Operand bits 4, 2 and 0 have no effect on either enable.
- R3: A clear-form access clears the machine enable when operand bit 3 is one and clears the supervisor enable when operand bit 1 is one. Every other enable value is kept.
- R4: An interrupt is available only when all of the following hold. Vectored mode is on. The pending privilege equals 2'b11 (machine). The pending level is strictly greater than the level threshold. The pending level is strictly greater than the comparison level. In the immediate form the comparison level is the previous-level input.
- R5: In the register form, the comparison level is operand bits 23:16 instead of the previous-level input.
- R6: An available interrupt is committed on the strobed edge only when side effects are allowed: in the immediate form the 5-bit immediate must be non-zero, and in the register form the source must not be x0. A commit loads the current level with the pending level and the cause code with the pending ID. Otherwise both fields hold.
- R7: While an interrupt is available, the destination value equals the table base plus the pending ID times 4. Otherwise the destination value is zero, and with vectored mode off it is always zero with no commit.
- R8: A register-form access whose source is x0 changes neither enable, nor the current level, nor the cause code. It still returns the value given by R7.
- R9: While the strobe is low, no state changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Access strobe, one cycle per access |
| accSet | input | 1 | 1 = set form, 0 = clear form |
| accImm | input | 1 | 1 = immediate form, 0 = register form |
| immVal | input | 5 | Immediate operand |
| srcVal | input | 32 | Register-form source operand |
| srcIsZeroReg | input | 1 | Register-form source is x0 |
| pendPriv | input | 2 | Privilege of highest-ranked pending interrupt |
| pendLevel | input | 8 | Level of that interrupt |
| pendId | input | 12 | ID of that interrupt |
| prevLevel | input | 8 | Previous interrupt level held in the cause register |
| levelThresh | input | 8 | Machine level threshold |
| vecMode | input | 1 | Controller is in vectored interrupt mode |
| tableBase | input | 32 | Vector table base address |
| rdData | output | 32 | Value for the destination register |
| mieBit | output | 1 | Machine interrupt enable |
| sieBit | output | 1 | Supervisor interrupt enable |
| curLevel | output | 8 | Current interrupt level of the hart |
| causeCode | output | 12 | Exception-code field of the cause register |

## Verification
The hardest case to reach is one where an interrupt is available but no commit may happen. This arises in two ways: a zero immediate, or a register-form read of x0. In both cases the returned address must still be correct while level and cause stay frozen. It takes a committed state that differs from the pending interrupt to see this. The stimulus therefore first commits to one interrupt, then presents a different, qualifying interrupt with a zero immediate and with an x0 source, and checks that the outputs still show the first interrupt. Register-form accesses also use a comparison field that disagrees with the previous-level input, so that a swapped comparison source shows up.

// File: rtl/nxti_pkg.sv
package nxti_pkg;
  localparam int MIE_POS = 3;
  localparam int SIE_POS = 1;
  localparam int CMP_LSB = 16;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic enWrite;   // apply enable update this edge
    logic setForm;   // OR when 1, AND-NOT when 0
    logic commit;    // load level and cause this edge
    logic avail;     // a qualifying interrupt is present
  } nxtiStrobe_t;
endpackage

// File: rtl/nxti_ctrl.sv
module nxti_ctrl
  import nxti_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int XLEN  = 32,
  parameter int IMM_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accSet,
  input  logic              accImm,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic              srcIsZeroReg,
  input  logic [1:0]        pendPriv,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [LVL_W-1:0]  prevLevel,
  input  logic [LVL_W-1:0]  levelThresh,
  input  logic              vecMode,
  output nxtiStrobe_t       strobes,
  output logic              mieOp,
  output logic              sieOp
);
  localparam int CMP_MSB = CMP_LSB + LVL_W - 1;

  logic [XLEN-1:0]  opBits;
  logic [LVL_W-1:0] cmpLevel;
  logic             beatsCmp;
  logic             beatsThresh;
  logic             isMachine;
  logic             sideOk;
  logic             availNow;

  always_comb begin
    opBits    = accImm ? XLEN'(immVal) : srcVal;
    mieOp     = opBits[MIE_POS];
    sieOp     = opBits[SIE_POS];
    cmpLevel  = accImm ? prevLevel : srcVal[CMP_MSB:CMP_LSB];
    beatsCmp    = pendLevel > cmpLevel;
    beatsThresh = pendLevel > levelThresh;
    isMachine   = pendPriv == PRIV_MACHINE;
    availNow    = vecMode && isMachine && beatsCmp && beatsThresh;
    sideOk      = accImm ? (immVal != '0) : !srcIsZeroReg;

    strobes.avail   = availNow;
    strobes.setForm = accSet;
    strobes.enWrite = accValid && (accImm || !srcIsZeroReg);
    strobes.commit  = accValid && availNow && sideOk;
  end

  // Commits only ever follow a machine-level interrupt above threshold
  p_commit_machine_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (pendPriv == PRIV_MACHINE) && (pendLevel > levelThresh) && vecMode);

  // x0 register source never produces a write strobe
  p_x0_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!accImm && srcIsZeroReg) |-> !strobes.enWrite && !strobes.commit);
endmodule

// File: rtl/nxti_dp.sv
module nxti_dp
  import nxti_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int ID_W  = 12,
  parameter int XLEN  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  nxtiStrobe_t       strobes,
  input  logic              mieOp,
  input  logic              sieOp,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [ID_W-1:0]   pendId,
  input  logic [XLEN-1:0]   tableBase,
  output logic [XLEN-1:0]   rdData,
  output logic              mieBit,
  output logic              sieBit,
  output logic [LVL_W-1:0]  curLevel,
  output logic [ID_W-1:0]   causeCode
);
  localparam int ENTRY_BYTES = XLEN / 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic mieNext;
  logic sieNext;
  logic [XLEN-1:0] entryOffset;

  generate
    if (ENTRY_SHIFT == 0) begin : g_noShift
      assign entryOffset = XLEN'(pendId);
    end else begin : g_shift
      assign entryOffset = {XLEN'(pendId)} << ENTRY_SHIFT;
    end
  endgenerate

  always_comb begin
    if (strobes.setForm) begin
      mieNext = mieBit | mieOp;
      sieNext = sieBit | sieOp;
    end else begin
      mieNext = mieBit & ~mieOp;
      sieNext = sieBit & ~sieOp;
    end
    rdData = strobes.avail ? (tableBase + entryOffset) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mieBit <= 1'b0;
      sieBit <= 1'b0;
    end else if (strobes.enWrite) begin
      mieBit <= mieNext;
      sieBit <= sieNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel  <= '0;
      causeCode <= '0;
    end else if (strobes.commit) begin
      curLevel  <= pendLevel;
      causeCode <= pendId;
    end
  end

  p_commit_loads_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (curLevel == $past(pendLevel)) && (causeCode == $past(pendId)));

  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.enWrite && !strobes.commit) |=>
      $stable(mieBit) && $stable(sieBit) && $stable(curLevel) && $stable(causeCode));

  p_zero_unless_avail_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.avail |-> rdData == '0);
endmodule

// File: rtl/nxti_access_unit.sv
module nxti_access_unit
  import nxti_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int ID_W  = 12,
  parameter int XLEN  = 32,
  parameter int IMM_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accSet,
  input  logic              accImm,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic              srcIsZeroReg,
  input  logic [1:0]        pendPriv,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [ID_W-1:0]   pendId,
  input  logic [LVL_W-1:0]  prevLevel,
  input  logic [LVL_W-1:0]  levelThresh,
  input  logic              vecMode,
  input  logic [XLEN-1:0]   tableBase,
  output logic [XLEN-1:0]   rdData,
  output logic              mieBit,
  output logic              sieBit,
  output logic [LVL_W-1:0]  curLevel,
  output logic [ID_W-1:0]   causeCode
);
  nxtiStrobe_t strobes;
  logic        mieOp;
  logic        sieOp;

  nxti_ctrl #(.LVL_W(LVL_W), .XLEN(XLEN), .IMM_W(IMM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accImm(accImm),
    .immVal(immVal), .srcVal(srcVal), .srcIsZeroReg(srcIsZeroReg),
    .pendPriv(pendPriv), .pendLevel(pendLevel), .prevLevel(prevLevel),
    .levelThresh(levelThresh), .vecMode(vecMode),
    .strobes(strobes), .mieOp(mieOp), .sieOp(sieOp)
  );

  nxti_dp #(.LVL_W(LVL_W), .ID_W(ID_W), .XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mieOp(mieOp), .sieOp(sieOp),
    .pendLevel(pendLevel), .pendId(pendId), .tableBase(tableBase),
    .rdData(rdData), .mieBit(mieBit), .sieBit(sieBit),
    .curLevel(curLevel), .causeCode(causeCode)
  );

  p_x0_read_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accImm && srcIsZeroReg) |=>
      $stable(mieBit) && $stable(sieBit) && $stable(curLevel) && $stable(causeCode));

  p_flat_mode_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !vecMode |-> rdData == '0);

  p_flat_mode_no_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !vecMode) |=> $stable(curLevel) && $stable(causeCode));
endmodule

// File: tb/tb_nxti_access_unit.sv
module tb_nxti_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  typedef struct packed {
    logic        st;  logic        im;  logic [4:0]  iv;  logic [31:0] sv;
    logic        z;   logic [1:0]  pr;  logic [7:0]  lv;  logic [11:0] id;
    logic [7:0]  pv;  logic [7:0]  th;  logic        vm;
    logic [31:0] eRd; logic        eM;  logic        eS;  logic [7:0]  eLv; logic [11:0] eCd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [0:NV-1] = '{
    // R2 R4 R6: set imm bits 3,1, qualifies, commits
    '{1'b1,1'b1,5'b01010,32'h0,1'b0,2'b11,8'd5,12'd7,8'd2,8'd3,1'b1, 32'h101C,1'b1,1'b1,8'd5,12'd7},
    // R3 R4: clear bit3; level equals previous -> not available
    '{1'b0,1'b1,5'b01000,32'h0,1'b0,2'b11,8'd5,12'd7,8'd5,8'd0,1'b1, 32'h0,1'b0,1'b1,8'd5,12'd7},
    // R2: bits 4,2,0 only; level equals threshold -> not available
    '{1'b1,1'b1,5'b10101,32'h0,1'b0,2'b11,8'd9,12'd3,8'd5,8'd9,1'b1, 32'h0,1'b0,1'b1,8'd5,12'd7},
    // R6 R7: zero immediate, available, address but no commit
    '{1'b1,1'b1,5'b00000,32'h0,1'b0,2'b11,8'd9,12'd3,8'd5,8'd8,1'b1, 32'h100C,1'b0,1'b1,8'd5,12'd7},
    // R5: register form compares bits 23:16 (4), not previous level 200
    '{1'b1,1'b0,5'b0,32'h0004_0008,1'b0,2'b11,8'd6,12'd20,8'd200,8'd2,1'b1, 32'h1050,1'b1,1'b1,8'd6,12'd20},
    // R3 R5: register clear bit1; field 255 blocks
    '{1'b0,1'b0,5'b0,32'h00FF_0002,1'b0,2'b11,8'd6,12'd20,8'd0,8'd0,1'b1, 32'h0,1'b1,1'b0,8'd6,12'd20},
    // R8: x0 source, available, address returned, nothing changes
    '{1'b1,1'b0,5'b0,32'h0000_000A,1'b1,2'b11,8'd7,12'd9,8'd0,8'd0,1'b1, 32'h1024,1'b1,1'b0,8'd6,12'd20},
    // R4: privilege not machine -> not available; enable still updated
    '{1'b1,1'b1,5'b00010,32'h0,1'b0,2'b01,8'd50,12'd1,8'd0,8'd0,1'b1, 32'h0,1'b1,1'b1,8'd6,12'd20},
    // R7: vectored mode off -> zero, no commit
    '{1'b1,1'b1,5'b01000,32'h0,1'b0,2'b11,8'd50,12'd1,8'd0,8'd0,1'b0, 32'h0,1'b1,1'b1,8'd6,12'd20}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accSet = 1'b0, accImm = 1'b0, srcIsZeroReg = 1'b0, vecMode = 1'b0;
  logic [4:0]  immVal = '0;
  logic [31:0] srcVal = '0;
  logic [1:0]  pendPriv = '0;
  logic [7:0]  pendLevel = '0, prevLevel = '0, levelThresh = '0;
  logic [11:0] pendId = '0;
  logic [31:0] tableBase = BASE;
  logic [31:0] rdData;
  logic        mieBit, sieBit;
  logic [7:0]  curLevel;
  logic [11:0] causeCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nxti_access_unit dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accImm(accImm),
    .immVal(immVal), .srcVal(srcVal), .srcIsZeroReg(srcIsZeroReg),
    .pendPriv(pendPriv), .pendLevel(pendLevel), .pendId(pendId),
    .prevLevel(prevLevel), .levelThresh(levelThresh), .vecMode(vecMode),
    .tableBase(tableBase), .rdData(rdData), .mieBit(mieBit), .sieBit(sieBit),
    .curLevel(curLevel), .causeCode(causeCode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic m, input logic s,
                          input logic [7:0] l, input logic [11:0] c);
    chk({tag, " machine enable"}, 32'(mieBit), 32'(m));
    chk({tag, " supervisor enable"}, 32'(sieBit), 32'(s));
    chk({tag, " level"}, 32'(curLevel), 32'(l));
    chk({tag, " cause"}, 32'(causeCode), 32'(c));
  endtask

  task automatic drive(input vec_t v, input logic valid);
    accSet = v.st; accImm = v.im; immVal = v.iv; srcVal = v.sv; srcIsZeroReg = v.z;
    pendPriv = v.pr; pendLevel = v.lv; pendId = v.id; prevLevel = v.pv;
    levelThresh = v.th; vecMode = v.vm; accValid = valid;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chkState("R1 reset", 1'b0, 1'b0, 8'd0, 12'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i], 1'b1);
      #1;
      chk($sformatf("R7 vector %0d rdData", i), rdData, VECS[i].eRd);
      @(posedge clk);
      #1;
      accValid = 1'b0;
      chkState($sformatf("R2/R3/R6 vector %0d", i), VECS[i].eM, VECS[i].eS, VECS[i].eLv, VECS[i].eCd);
    end

    // R9: strobe low with a pattern that would commit and clear both enables
    @(negedge clk);
    drive('{1'b0,1'b1,5'b01010,32'h0,1'b0,2'b11,8'd90,12'd44,8'd0,8'd0,1'b1,
            32'h0,1'b0,1'b0,8'd0,12'd0}, 1'b0);
    #1;
    chk("R7 idle address", rdData, BASE + 32'd176);
    repeat (2) @(posedge clk);
    #1;
    chkState("R9 idle", 1'b1, 1'b1, 8'd6, 12'd20);

    // R6: register form clear with non-x0 source still commits
    @(negedge clk);
    drive('{1'b0,1'b0,5'b0,32'h0001_0000,1'b0,2'b11,8'd90,12'd44,8'd0,8'd0,1'b1,
            32'h0,1'b0,1'b0,8'd0,12'd0}, 1'b1);
    @(posedge clk);
    #1;
    accValid = 1'b0;
    chkState("R6 register clear commit", 1'b1, 1'b1, 8'd90, 12'd44);

    // R1: reset again after activity
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chkState("R1 second reset", 1'b0, 1'b0, 8'd0, 12'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule